// File: doc/BRIEF.md
# Interrupt Flag and Wake Controller for a Small 8-bit Core

This block gathers three interrupt sources for a small 8-bit processor core: a one-cycle pulse from an 8-bit timer when it wraps from FFh to 00h, an external pin whose active edge is picked by an option input, and a group of three general-purpose inputs watched for any change. Each source latches a flag in an 8-bit control register. The flag latches whether or not that source is enabled. The core reads the register, writes it whole, or clears selected bits through a bit-clear strobe. Hardware never clears a flag.

The block drives three outputs towards the core. `irq` is the request taken while the core runs. `wake` is a one-cycle pulse that ends sleep. `branch` tells the core, at wake-up, whether to jump to the interrupt vector or go on with the next instruction. Wake-up needs only a pending flag whose own enable is set. The global enable bit then decides only whether the core branches. The core acknowledges vectoring with `vec_ack`, which clears the global enable, and its return strobe `reti` sets it again.

A small sequencer follows the core's power state. It has three states. `ST_RUN` is normal execution. `ST_SLEEP` is entered on `sleep_req`. `ST_WAKE` lasts one cycle and produces the wake pulse. The transitions are:
- RUN to SLEEP when `sleep_req` is seen.
- SLEEP to WAKE once any enabled flag is pending.
- WAKE to RUN unconditionally.

Control register layout (bit: meaning):
- 7: global enable
- 6: reads 0
- 5: timer enable
- 4: external-pin enable
- 3: pin-change enable
- 2: timer flag
- 1: external-pin flag
- 0: pin-change flag

Top module: `irqc_top`

## Requirements
- R1: A one-cycle `tmr_ovf` pulse sets bit 2 of the control register at the next clock edge, even when the timer enable (bit 5) is 0.
- R2: With `edge_rise`=1, a rising edge on `ext_pin` sets bit 1 and a falling edge has no effect. With `edge_rise`=0, the falling edge sets bit 1 and the rising edge has no effect. The flag appears within four clocks of the pin change.
- R3: When any of the `gp_pin` inputs differs from the value latched by the most recent `reg_rd` strobe, bit 0 is set, even when the change enable (bit 3) is 0. While the difference remains, the flag sets again after being cleared.
- R4: Flags change only through software. `reg_wr` loads `reg_wdata`. `reg_clr` clears every bit that is 1 in `reg_wdata`. `vec_ack`, `reti` and the sleep sequencer never clear a flag.
- R5: When a source event and a software write or bit-clear of the same flag fall in the same cycle, the flag ends up set.
- R6: While running, `irq` equals bit 7 ANDed with the OR of (bit 5 & bit 2), (bit 4 & bit 1) and (bit 3 & bit 0). Bit 6 always reads 0.
- R7: `vec_ack` clears bit 7 at the next edge. `reti` sets bit 7 at the next edge.
- R8: `sleep_req` moves the sequencer from RUN to SLEEP, where `irq` is held at 0. Once an enabled flag is pending, the sequencer moves to WAKE and `wake` pulses high for exactly one cycle, starting one cycle after the flag becomes visible.
- R9: During the wake pulse, `branch` equals bit 7. With bit 7 at 0, the core wakes without branching.
- R10: In SLEEP, a flag whose enable is 0 does not wake the core. Setting that enable while the flag is pending produces the wake pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tmr_ovf | input | 1 | One-cycle timer wrap pulse |
| ext_pin | input | 1 | External interrupt pin (asynchronous) |
| gp_pin | input | NUM_GP | General-purpose inputs watched for change (asynchronous) |
| edge_rise | input | 1 | 1 selects rising edge on ext_pin, 0 selects falling edge |
| reg_wr | input | 1 | Write reg_wdata into the control register |
| reg_clr | input | 1 | Clear the control register bits set in reg_wdata |
| reg_rd | input | 1 | Read strobe; latches the pin-change reference |
| reg_wdata | input | 8 | Write data or clear mask |
| reg_rdata | output | 8 | Control register contents |
| vec_ack | input | 1 | Core has vectored; clears global enable |
| reti | input | 1 | Return-from-interrupt strobe; sets global enable |
| sleep_req | input | 1 | Core executes sleep |
| irq | output | 1 | Interrupt request while running |
| wake | output | 1 | One-cycle wake pulse out of sleep |
| branch | output | 1 | Branch to vector on this wake |

## Verification
The bench targets four corner cases:
- It pits a timer pulse against a write and against a bit-clear in the same cycle. A design where software wins would lose the event and read bit 2 as 0.
- It drives each edge of `ext_pin` under both option settings. A detector that is level-sensitive, or wired to the wrong polarity, would set bit 1 on the ignored edge.
- For the pin-change source, it clears the flag before any read and again after one. A design that compares against the previous clock sample instead of the read-latched reference would leave the flag clear in the first case.
- It sleeps with the global enable off, and again with a pending flag whose enable is clear. A wake-up gated on the global enable would never leave sleep, and one that ignores the per-source enable would wake too early.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int REG_W  = 8;
    localparam int B_GIE  = 7;
    localparam int B_RSV  = 6;
    localparam int B_TIE  = 5;
    localparam int B_XIE  = 4;
    localparam int B_CIE  = 3;
    localparam int B_TF   = 2;
    localparam int B_XF   = 1;
    localparam int B_CF   = 0;
    localparam int N_SRC  = 3;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_SLEEP = 2'd1,
        ST_WAKE  = 2'd2
    } core_st_e;
endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= '0;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/irqc_evdet.sv
module irqc_evdet #(
    parameter int NUM_GP = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_s,
    input  logic [NUM_GP-1:0] gp_s,
    input  logic              edge_rise,
    input  logic              ref_load,
    output logic              ext_evt,
    output logic              chg_evt
);
    logic              ext_prev;
    logic [NUM_GP-1:0] gp_ref;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ext_prev <= 1'b0;
            gp_ref   <= '0;
        end else begin
            ext_prev <= ext_s;
            if (ref_load) gp_ref <= gp_s;
        end
    end

    always_comb begin
        if (edge_rise) ext_evt = ext_s & ~ext_prev;
        else           ext_evt = ~ext_s & ext_prev;
        chg_evt = |(gp_s ^ gp_ref);
    end
endmodule

// File: rtl/irqc_flags.sv
module irqc_flags
    import irqc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic             clr,
    input  logic [REG_W-1:0] wdata,
    input  logic             vec_ack,
    input  logic             reti,
    input  logic [N_SRC-1:0] src_evt,
    output logic [REG_W-1:0] ctl_q
);
    logic [REG_W-1:0] ctl_d;

    always_comb begin
        ctl_d = ctl_q;
        if (wr)       ctl_d = wdata;
        else if (clr) ctl_d = ctl_q & ~wdata;
        if (vec_ack)  ctl_d[B_GIE] = 1'b0;
        if (reti)     ctl_d[B_GIE] = 1'b1;
        ctl_d[B_CF+N_SRC-1:B_CF] = ctl_d[B_CF+N_SRC-1:B_CF] | src_evt;
        ctl_d[B_RSV] = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end
endmodule

// File: rtl/irqc_fsm.sv
module irqc_fsm
    import irqc_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     sleep_req,
    input  logic     pend,
    input  logic     gie,
    output logic     irq,
    output logic     wake,
    output logic     branch
);
    core_st_e st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_RUN;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_RUN:   if (sleep_req) st_d = ST_SLEEP;
            ST_SLEEP: if (pend)      st_d = ST_WAKE;
            ST_WAKE:                 st_d = ST_RUN;
            default:                 st_d = ST_RUN;
        endcase
    end

    always_comb begin
        irq    = 1'b0;
        wake   = 1'b0;
        branch = 1'b0;
        unique case (st_q)
            ST_RUN:   irq = gie & pend;
            ST_SLEEP: ;
            ST_WAKE: begin
                wake   = 1'b1;
                branch = gie;
            end
            default:  ;
        endcase
    end
endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
#(
    parameter int NUM_GP      = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tmr_ovf,
    input  logic              ext_pin,
    input  logic [NUM_GP-1:0] gp_pin,
    input  logic              edge_rise,
    input  logic              reg_wr,
    input  logic              reg_clr,
    input  logic              reg_rd,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              vec_ack,
    input  logic              reti,
    input  logic              sleep_req,
    output logic              irq,
    output logic              wake,
    output logic              branch
);
    localparam int SW = NUM_GP + 1;

    logic [SW-1:0]     pins_s;
    logic              ext_evt, chg_evt;
    logic [REG_W-1:0]  ctl;
    logic [N_SRC-1:0]  src_evt;
    logic              pend;

    irqc_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d({ext_pin, gp_pin}), .q(pins_s)
    );

    irqc_evdet #(.NUM_GP(NUM_GP)) u_evdet (
        .clk(clk), .rst_n(rst_n),
        .ext_s(pins_s[SW-1]), .gp_s(pins_s[NUM_GP-1:0]),
        .edge_rise(edge_rise), .ref_load(reg_rd),
        .ext_evt(ext_evt), .chg_evt(chg_evt)
    );

    assign src_evt = {tmr_ovf, ext_evt, chg_evt};

    irqc_flags u_flags (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .clr(reg_clr),
        .wdata(reg_wdata), .vec_ack(vec_ack), .reti(reti),
        .src_evt(src_evt), .ctl_q(ctl)
    );

    assign pend = |(ctl[B_TIE:B_CIE] & ctl[B_TF:B_CF]);

    irqc_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .pend(pend),
        .gie(ctl[B_GIE]), .irq(irq), .wake(wake), .branch(branch)
    );

    assign reg_rdata = ctl;
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tmr_ovf,
    input logic       reg_wr,
    input logic       reg_clr,
    input logic [7:0] reg_rdata,
    input logic       vec_ack,
    input logic       reti,
    input logic       irq,
    input logic       wake,
    input logic       branch
);
    assert_tmr_flag_R1: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_ovf |=> reg_rdata[2]);

    assert_no_hw_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_wr && !reg_clr) |=> ((reg_rdata[2:0] & $past(reg_rdata[2:0])) == $past(reg_rdata[2:0])));

    assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_ovf && (reg_wr || reg_clr)) |=> reg_rdata[2]);

    assert_irq_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (reg_rdata[7] && ((reg_rdata[5:3] & reg_rdata[2:0]) != 3'b000)));

    assert_rsv_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rdata[6]);

    assert_vec_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_ack && !reti) |=> !reg_rdata[7]);

    assert_reti_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
        reti |=> reg_rdata[7]);

    assert_wake_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wake |=> !wake);

    assert_no_irq_on_wake_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wake |-> !irq);

    assert_branch_gie_R9: assert property (@(posedge clk) disable iff (!rst_n)
        branch |-> (wake && reg_rdata[7]));
endmodule

bind irqc_top irqc_chk u_chk (
    .clk(clk), .rst_n(rst_n), .tmr_ovf(tmr_ovf), .reg_wr(reg_wr),
    .reg_clr(reg_clr), .reg_rdata(reg_rdata), .vec_ack(vec_ack),
    .reti(reti), .irq(irq), .wake(wake), .branch(branch)
);

// File: tb/irqc_top_test.sv
module irqc_top_test;
    localparam int CLK_PERIOD = 10;
    localparam int N_VEC = 9;
    localparam logic [1:0] OP_WR = 2'd0, OP_CLR = 2'd1, OP_TMR = 2'd2;
    // entry: {op[1:0], data[7:0], expected register[7:0], expected irq}
    localparam logic [18:0] VEC [N_VEC] = '{
        {OP_WR,  8'h00, 8'h00, 1'b0},
        {OP_TMR, 8'h00, 8'h04, 1'b0},
        {OP_WR,  8'h20, 8'h20, 1'b0},
        {OP_TMR, 8'h00, 8'h24, 1'b0},
        {OP_WR,  8'hA4, 8'hA4, 1'b1},
        {OP_CLR, 8'h04, 8'hA0, 1'b0},
        {OP_WR,  8'hE0, 8'hA0, 1'b0},
        {OP_TMR, 8'h00, 8'hA4, 1'b1},
        {OP_CLR, 8'h80, 8'h24, 1'b0}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tmr_ovf = 1'b0, ext_pin = 1'b0, edge_rise = 1'b1;
    logic [2:0] gp_pin = 3'b000;
    logic       reg_wr = 1'b0, reg_clr = 1'b0, reg_rd = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       vec_ack = 1'b0, reti = 1'b0, sleep_req = 1'b0;
    logic       irq, wake, branch;
    int         checks = 0, failures = 0;
    bit         done = 1'b0;

    irqc_top uut (
        .clk(clk), .rst_n(rst_n), .tmr_ovf(tmr_ovf), .ext_pin(ext_pin),
        .gp_pin(gp_pin), .edge_rise(edge_rise), .reg_wr(reg_wr),
        .reg_clr(reg_clr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .vec_ack(vec_ack), .reti(reti),
        .sleep_req(sleep_req), .irq(irq), .wake(wake), .branch(branch)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_wr(input logic [7:0] d);
        reg_wr = 1'b1; reg_wdata = d; step(1); reg_wr = 1'b0;
    endtask

    task automatic do_clr(input logic [7:0] m);
        reg_clr = 1'b1; reg_wdata = m; step(1); reg_clr = 1'b0;
    endtask

    task automatic do_tmr();
        tmr_ovf = 1'b1; step(1); tmr_ovf = 1'b0;
    endtask

    task automatic do_rd();
        reg_rd = 1'b1; step(1); reg_rd = 1'b0;
    endtask

    task automatic do_sleep();
        sleep_req = 1'b1; step(1); sleep_req = 1'b0;
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        chk("R4 reset register", reg_rdata, 8'h00);
        chk("R6 reset irq", {7'b0, irq}, 8'h00);
        chk("R8 reset wake", {6'b0, wake, branch}, 8'h00);

        // vector table: R1 R4 R6
        for (int i = 0; i < N_VEC; i++) begin
            logic [18:0] e;
            e = VEC[i];
            unique case (e[18:17])
                OP_WR:   do_wr(e[16:9]);
                OP_CLR:  do_clr(e[16:9]);
                default: do_tmr();
            endcase
            chk($sformatf("R1/R4 vector %0d register", i), reg_rdata, e[8:1]);
            chk($sformatf("R6 vector %0d irq", i), {7'b0, irq}, {7'b0, e[0]});
        end

        // R7 vectoring and return
        do_wr(8'hA4);
        vec_ack = 1'b1; step(1); vec_ack = 1'b0;
        chk("R7 vec_ack clears global enable", reg_rdata, 8'h24);
        chk("R7 irq after vec_ack", {7'b0, irq}, 8'h00);
        reti = 1'b1; step(1); reti = 1'b0;
        chk("R7 reti sets global enable", reg_rdata, 8'hA4);

        // R5 set wins
        reg_wr = 1'b1; reg_wdata = 8'h00; tmr_ovf = 1'b1; step(1);
        reg_wr = 1'b0; tmr_ovf = 1'b0;
        chk("R5 write vs timer event", reg_rdata, 8'h04);
        reg_clr = 1'b1; reg_wdata = 8'h04; tmr_ovf = 1'b1; step(1);
        reg_clr = 1'b0; tmr_ovf = 1'b0;
        chk("R5 bit-clear vs timer event", reg_rdata, 8'h04);

        // R2 external edge selection
        do_wr(8'h00);
        edge_rise = 1'b1; ext_pin = 1'b1; step(4);
        chk("R2 rising edge, rise mode", reg_rdata, 8'h02);
        do_clr(8'h02);
        ext_pin = 1'b0; step(4);
        chk("R2 falling edge ignored, rise mode", reg_rdata, 8'h00);
        edge_rise = 1'b0; step(1);
        ext_pin = 1'b1; step(4);
        chk("R2 rising edge ignored, fall mode", reg_rdata, 8'h00);
        ext_pin = 1'b0; step(4);
        chk("R2 falling edge, fall mode", reg_rdata, 8'h02);

        // R3 pin change against read-latched reference
        do_wr(8'h00);
        do_rd();
        gp_pin = 3'b010; step(4);
        chk("R3 change sets flag", reg_rdata, 8'h01);
        do_clr(8'h01);
        chk("R3 flag re-sets while unread", reg_rdata, 8'h01);
        do_rd();
        do_clr(8'h01);
        step(3);
        chk("R3 cleared after read", reg_rdata, 8'h00);
        gp_pin = 3'b000; step(4);
        chk("R3 change back sets flag", reg_rdata, 8'h01);
        do_rd();

        // R8 R9 sleep with global enable off
        do_wr(8'h00);
        do_wr(8'h20);
        do_sleep();
        chk("R8 asleep no wake", {6'b0, wake, branch}, 8'h00);
        do_tmr();
        chk("R8 wake not yet", {6'b0, wake, branch}, 8'h00);
        step(1);
        chk("R9 wake without branch", {6'b0, wake, branch}, 8'h02);
        step(1);
        chk("R8 wake single pulse", {6'b0, wake, branch}, 8'h00);
        chk("R6 running, global enable off", {7'b0, irq}, 8'h00);

        // R8 R9 sleep with global enable on
        do_wr(8'h00);
        do_wr(8'hA0);
        do_sleep();
        chk("R8 irq held low asleep", {7'b0, irq}, 8'h00);
        do_tmr();
        step(1);
        chk("R9 wake with branch", {6'b0, wake, branch}, 8'h03);
        step(1);
        chk("R8 back to run, irq", {6'b0, wake, irq}, 8'h01);

        // R10 disabled flag does not wake
        do_wr(8'h00);
        do_wr(8'h80);
        do_sleep();
        do_tmr();
        step(3);
        chk("R10 no wake on disabled flag", {6'b0, wake, irq}, 8'h00);
        chk("R10 flag latched asleep", reg_rdata, 8'h84);
        do_wr(8'hA4);
        chk("R10 wake not yet after enable", {6'b0, wake, branch}, 8'h00);
        step(1);
        chk("R10 wake after enable", {6'b0, wake, branch}, 8'h03);
        step(2);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule